// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two two-level predictors run side by side, and a third table picks between them for each branch. The local predictor keeps a short outcome history for each branch and uses it to select a 2-bit counter. The global predictor keeps one shift register of recent outcomes across all branches and uses it to select a counter in a second table. A chooser table of 2-bit counters, indexed by branch address, decides which of the two predictions is returned.

The fetch side drives a branch address and reads the prediction combinationally in the same cycle. The resolve side reports a retired branch address and its real outcome. The next clock edge then trains the counters of both components and the chooser, and shifts both histories. Histories are non-speculative because they change only through the resolve side.

Every table size is a parameter. The full-size build uses 10 address bits into the local history table, 10-bit local histories (1K local counters), 12-bit global history (4K global counters) and a 4K-entry chooser. The default parameters give a reduced build of the same shape.

Top module: `tbp_top`

## Requirements
- R1: While reset is held, every counter in all three tables is set to 1 (weakly not-taken) and every history is set to 0. Right after reset, every branch address is predicted not-taken.
- R2: Every counter saturates at 2 bits: a taken outcome adds 1 up to a ceiling of 3, a not-taken outcome subtracts 1 down to a floor of 0. A counter votes taken when its value is 2 or 3.
- R3: The local history entry is chosen by address bits `[PC_LSB +: LPC_W]`. Its value chooses the local counter. On each update the outcome is shifted into bit 0 of that entry (1 = taken), and the oldest bit is dropped.
- R4: A single global history register chooses the global counter. Every accepted update shifts that outcome into bit 0 of the register.
- R5: The chooser entry is chosen by address bits `[PC_LSB +: CH_W]`. A value of 2 or 3 returns the global vote and a value of 0 or 1 returns the local vote. When the two votes agree, that common vote is returned.
- R6: The chooser entry of the updated branch changes only when the local and global votes for that branch disagree. It moves up by one if the global vote matched the outcome and down by one if the local vote did, saturating like any other counter.
- R7: `pred_taken` is a combinational function of `pred_pc` and the current tables. An update takes effect at the next rising clock edge. When `upd_valid` is low, no table or history changes, whatever `upd_pc` and `upd_taken` carry.
- R8: When the same address is predicted and updated in one cycle, the prediction reflects the tables as they stand before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench builds the predictor with 8 local history entries of 4 bits, a 4-bit global history and an 8-entry chooser. With tables this small, counters reach saturation within a few updates. Local and global histories also wrap through every value, and branches alias onto shared chooser and history entries. The outcome stream mixes branches that repeat a fixed period with branches that follow the previous global outcome. This makes the two components disagree often enough for the chooser to swing both ways.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'd1;

    function automatic ctr_t ctr_next(input ctr_t c, input logic up);
        ctr_t r;
        if (up) r = (c == 2'd3) ? c : c + 2'd1;
        else    r = (c == 2'd0) ? c : c - 2'd1;
        return r;
    endfunction

    function automatic logic ctr_vote(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/tbp_local.sv
module tbp_local
    import tbp_pkg::*;
#(
    parameter int LPC_W = 8,
    parameter int LH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LPC_W-1:0] p_idx,
    output logic             p_vote,
    input  logic             u_valid,
    input  logic [LPC_W-1:0] u_idx,
    input  logic             u_taken,
    output logic             u_vote,
    output logic [LH_W-1:0]  u_hist
);
    localparam int H_ENT = 1 << LPC_W;
    localparam int C_ENT = 1 << LH_W;

    typedef struct packed {
        logic [H_ENT-1:0][LH_W-1:0] hist;
        ctr_t [C_ENT-1:0]           ctr;
    } lstate_t;

    lstate_t st_d, st_q;
    logic [LH_W-1:0] p_hist;

    assign p_hist = st_q.hist[p_idx];
    assign u_hist = st_q.hist[u_idx];
    assign p_vote = ctr_vote(st_q.ctr[p_hist]);
    assign u_vote = ctr_vote(st_q.ctr[u_hist]);

    always_comb begin
        st_d = st_q;
        if (u_valid) begin
            st_d.ctr[u_hist]  = ctr_next(st_q.ctr[u_hist], u_taken);
            st_d.hist[u_idx]  = {u_hist[LH_W-2:0], u_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist <= '0;
            for (int i = 0; i < C_ENT; i++) st_q.ctr[i] <= CTR_INIT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tbp_global.sv
module tbp_global
    import tbp_pkg::*;
#(
    parameter int GH_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            u_valid,
    input  logic            u_taken,
    output logic            vote,
    output logic [GH_W-1:0] ghist
);
    localparam int G_ENT = 1 << GH_W;

    typedef struct packed {
        logic [GH_W-1:0]  hist;
        ctr_t [G_ENT-1:0] ctr;
    } gstate_t;

    gstate_t st_d, st_q;

    assign ghist = st_q.hist;
    assign vote  = ctr_vote(st_q.ctr[st_q.hist]);

    always_comb begin
        st_d = st_q;
        if (u_valid) begin
            st_d.ctr[st_q.hist] = ctr_next(st_q.ctr[st_q.hist], u_taken);
            st_d.hist           = {st_q.hist[GH_W-2:0], u_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist <= '0;
            for (int i = 0; i < G_ENT; i++) st_q.ctr[i] <= CTR_INIT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tbp_chooser.sv
module tbp_chooser
    import tbp_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] p_idx,
    output logic            p_use_glb,
    input  logic            u_valid,
    input  logic [CH_W-1:0] u_idx,
    input  logic            u_loc,
    input  logic            u_glb,
    input  logic            u_taken,
    output ctr_t            u_ctr
);
    localparam int S_ENT = 1 << CH_W;

    typedef struct packed {
        ctr_t [S_ENT-1:0] ctr;
    } cstate_t;

    cstate_t st_d, st_q;

    assign p_use_glb = ctr_vote(st_q.ctr[p_idx]);
    assign u_ctr     = st_q.ctr[u_idx];

    always_comb begin
        st_d = st_q;
        if (u_valid && (u_loc != u_glb)) begin
            st_d.ctr[u_idx] = ctr_next(u_ctr, u_glb == u_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < S_ENT; i++) st_q.ctr[i] <= CTR_INIT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tbp_top.sv
module tbp_top
    import tbp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int LPC_W  = 8,
    parameter int LH_W   = 8,
    parameter int GH_W   = 10,
    parameter int CH_W   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    logic            loc_p, glb_p, use_glb, loc_u;
    logic [LH_W-1:0] lh_u;
    logic [GH_W-1:0] ghist;
    ctr_t            ch_u;
    logic            unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc, upd_pc};

    tbp_local #(.LPC_W(LPC_W), .LH_W(LH_W)) u_local (
        .clk     (clk),
        .rst_n   (rst_n),
        .p_idx   (pred_pc[PC_LSB +: LPC_W]),
        .p_vote  (loc_p),
        .u_valid (upd_valid),
        .u_idx   (upd_pc[PC_LSB +: LPC_W]),
        .u_taken (upd_taken),
        .u_vote  (loc_u),
        .u_hist  (lh_u)
    );

    tbp_global #(.GH_W(GH_W)) u_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .u_valid (upd_valid),
        .u_taken (upd_taken),
        .vote    (glb_p),
        .ghist   (ghist)
    );

    tbp_chooser #(.CH_W(CH_W)) u_chooser (
        .clk       (clk),
        .rst_n     (rst_n),
        .p_idx     (pred_pc[PC_LSB +: CH_W]),
        .p_use_glb (use_glb),
        .u_valid   (upd_valid),
        .u_idx     (upd_pc[PC_LSB +: CH_W]),
        .u_loc     (loc_u),
        .u_glb     (glb_p),
        .u_taken   (upd_taken),
        .u_ctr     (ch_u)
    );

    assign pred_taken = use_glb ? glb_p : loc_p;
endmodule

// File: rtl/tbp_top_chk.sv
module tbp_top_chk #(
    parameter int PC_W = 32,
    parameter int LH_W = 8,
    parameter int GH_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pred_taken,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic            loc_p,
    input logic            glb_p,
    input logic            loc_u,
    input logic [LH_W-1:0] lh_u,
    input logic [GH_W-1:0] ghist,
    input logic [1:0]      ch_u
);
    // R1
    reset_not_taken_chk: assert property (@(posedge clk)
        !rst_n |=> !pred_taken);

    // R5
    agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_p == glb_p) |-> (pred_taken == loc_p));

    // R4
    ghist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist[0] == $past(upd_taken)));

    // R4
    ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])));

    // R7
    ghist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist));

    // R3
    lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && upd_pc == $past(upd_pc))
        |-> (lh_u == {$past(lh_u[LH_W-2:0]), $past(upd_taken)}));

    // R6
    chooser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && upd_pc == $past(upd_pc)
         && $past(loc_u == glb_p))
        |-> (ch_u == $past(ch_u)));

    // R6
    chooser_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && upd_pc == $past(upd_pc)
         && $past(loc_u != glb_p && glb_p == upd_taken && ch_u != 2'd3))
        |-> (ch_u == $past(ch_u) + 2'd1));
endmodule

bind tbp_top tbp_top_chk #(.PC_W(PC_W), .LH_W(LH_W), .GH_W(GH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .loc_p      (loc_p),
    .glb_p      (glb_p),
    .loc_u      (loc_u),
    .lh_u       (lh_u),
    .ghist      (ghist),
    .ch_u       (ch_u)
);

// File: tb/tbp_top_test.sv
module tbp_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 16;
    localparam int PC_LSB = 2;
    localparam int LPC_W  = 3;
    localparam int LH_W   = 4;
    localparam int GH_W   = 4;
    localparam int CH_W   = 3;
    localparam int NH = 1 << LPC_W;
    localparam int NL = 1 << LH_W;
    localparam int NG = 1 << GH_W;
    localparam int NC = 1 << CH_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int m_lh[NH];
    int m_lc[NL];
    int m_gh;
    int m_gc[NG];
    int m_ch[NC];

    tbp_top #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LPC_W(LPC_W), .LH_W(LH_W),
              .GH_W(GH_W), .CH_W(CH_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bump(int v, bit up);
        if (up) return (v < 3) ? v + 1 : 3;
        return (v > 0) ? v - 1 : 0;
    endfunction

    function automatic bit m_local(int pc);
        return m_lc[m_lh[(pc / (1 << PC_LSB)) % NH]] >= 2;
    endfunction

    function automatic bit m_global();
        return m_gc[m_gh] >= 2;
    endfunction

    function automatic bit m_predict(int pc);
        if (m_ch[(pc / (1 << PC_LSB)) % NC] >= 2) return m_global();
        return m_local(pc);
    endfunction

    task automatic m_reset();
        foreach (m_lh[i]) m_lh[i] = 0;
        foreach (m_lc[i]) m_lc[i] = 1;
        foreach (m_gc[i]) m_gc[i] = 1;
        foreach (m_ch[i]) m_ch[i] = 1;
        m_gh = 0;
    endtask

    task automatic m_update(int pc, bit t);
        int hi, ci, lh;
        bit lv, gv;
        hi = (pc / (1 << PC_LSB)) % NH;
        ci = (pc / (1 << PC_LSB)) % NC;
        lv = m_local(pc);
        gv = m_global();
        if (lv != gv) m_ch[ci] = bump(m_ch[ci], gv == t);
        lh = m_lh[hi];
        m_lc[lh] = bump(m_lc[lh], t);
        m_gc[m_gh] = bump(m_gc[m_gh], t);
        m_lh[hi] = ((lh * 2) + t) % NL;
        m_gh = ((m_gh * 2) + t) % NG;
    endtask

    task automatic step(int ppc, bit uv, int upc, bit ut, string tag);
        bit exp;
        @(negedge clk);
        pred_pc   = ppc[PC_W-1:0];
        upd_valid = uv;
        upd_pc    = upc[PC_W-1:0];
        upd_taken = ut;
        #1;
        exp = m_predict(ppc);
        checks++;
        if (pred_taken !== exp) begin
            errors++;
            $display("FAIL %s pc=%0h actual=%b expected=%b", tag, ppc, pred_taken, exp);
        end
        @(posedge clk);
        if (uv) m_update(upc, ut);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt[8];
        bit last;
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every address predicts not-taken after reset
        for (int k = 0; k < 16; k++) step(k * 4, 1'b0, 0, 1'b0, "R1");

        // R2: saturation up then down on one branch; R8 same-cycle predict/update
        for (int k = 0; k < 14; k++) step(8, 1'b1, 8, 1'b1, "R2/R8");
        for (int k = 0; k < 14; k++) step(8, 1'b1, 8, 1'b0, "R2/R8");

        // R7: held updates with valid low leave every prediction unchanged
        for (int k = 0; k < 16; k++) step(k * 4, 1'b0, 12, 1'b1, "R7");

        // R3: periodic local pattern on two branches
        for (int k = 0; k < 64; k++) begin
            step(16, 1'b1, 16, (k % 4) != 3, "R3");
            step(20, 1'b1, 20, (k % 3) == 0, "R3");
        end

        // R4/R5/R6: mixed local and global correlated stream
        foreach (cnt[i]) cnt[i] = 0;
        last = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            int b;
            bit t;
            bit uv;
            b  = $urandom % 8;
            uv = ($urandom % 5) != 0;
            if (b < 4) begin
                t = (cnt[b] % (b + 2)) != 0;
                if (uv) cnt[b]++;
            end else begin
                t = last ^ b[0];
            end
            if (($urandom % 32) == 0) t = ~t;
            if (uv) last = t;
            step(($urandom % 16) * 4, uv, b * 4 + (k % 2) * 32, t, "R4/R5/R6");
        end

        // R1: reset again in mid-run restores the initial state
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) step(k * 4, 1'b0, 0, 1'b0, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule